// File: doc/BRIEF.md
# Ethernet MAC Flow Control Controller

This block is the per-port flow control unit of a gigabit Ethernet MAC. It runs three mechanisms side by side, and each has its own enable bit. In half-duplex operation it applies back-pressure: when the receive FIFO fills past its high mark, it raises a jam request so that the receive path forces collisions on incoming traffic. In full-duplex operation it asks the transmit path to send pause frames. A pause frame goes out when the FIFO crosses its high mark or when an external agent asks for one, and a zero-time release frame follows once the FIFO drains below its low mark. When the link partner sends a pause, the block holds off transmission for the time carried in that frame.

Software reaches two registers through a simple write strobe and a one-bit select. A 3-bit enable word sits at select 0 and a 6-bit back-pressure length, counted in byte cycles, sits at select 1. Every timer in the block advances only on the byte-cycle strobe. Frame encoding and decoding, CRC, the FIFO itself and the PHY side all belong to neighbouring blocks.

Top module: `eth_fc_ctrl`

## Requirements
- R1: After reset, reading select 0 returns 0x7 (enable bit 2 = half-duplex back-pressure, bit 1 = pause generation, bit 0 = pause obedience) and reading select 1 returns 12. All outputs are low.
- R2: A write to select 0 keeps only write-data bits 2:0, and a write to select 1 keeps only bits 5:0. All other read-data bits read as zero.
- R3: With enable bit 2 set, half_duplex high and the back-pressure trigger armed, a sampled wm_high raises jam_req in the next cycle.
- R4: Once started, jam_req stays high for at least L byte-cycle strobes, where L is the length register, and a length of 0 counts as 1. With no carrier and a strobe every cycle, it stays high for exactly max(L,1) cycles.
- R5: While rx_carrier is high, jam_req stays asserted past the minimum length. It drops one cycle after the carrier falls, once the minimum has elapsed.
- R6: jam_req does not restart while wm_high stays high. It re-arms only after wm_high goes low. It drops the cycle after half_duplex goes low, and it never starts while enable bit 2 is clear.
- R7: In full duplex with enable bit 1 set, a sampled wm_high produces a one-cycle pause_send with pause_quanta equal to the XOFF_QUANTA parameter. No further high-mark pause is sent until a release has been sent.
- R8: After a high-mark pause, a sampled wm_low produces a pause_send with pause_quanta 0.
- R9: A rising edge on tx_pause_req produces a pause_send carrying tx_pause_quanta. A request that meets a watermark event in the same cycle is held and sent in the following cycle. A level that stays high does not send again.
- R10: With enable bit 1 clear or half_duplex high, pause_send stays low, and any pending request or high-mark state is dropped.
- R11: With enable bit 0 set, a received pause of time N holds tx_inhibit high for N x 2^QUANTUM_SHIFT byte strobes. A newer received pause reloads the timer.
- R12: A received pause time of 0 clears tx_inhibit in the next cycle. With enable bit 0 clear, received pauses are ignored and tx_inhibit stays low.
- R13: tx_inhibit rises only in a cycle following one where tx_frame_active was low, so a frame already in progress completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_tick | input | 1 | Byte-cycle strobe that advances all timers |
| half_duplex | input | 1 | 1 = link in half-duplex mode |
| wm_high | input | 1 | RX FIFO occupancy above high watermark |
| wm_low | input | 1 | RX FIFO occupancy below low watermark |
| rx_carrier | input | 1 | Incoming carrier currently active |
| tx_frame_active | input | 1 | Transmit frame in progress |
| tx_pause_req | input | 1 | External pause request, acted on at its rising edge |
| tx_pause_quanta | input | QUANTA_W | Pause time for the external request |
| rx_pause_valid | input | 1 | One-cycle strobe for a decoded received pause |
| rx_pause_time | input | QUANTA_W | Pause time carried by the received frame |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 enables, 1 back-pressure length |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| jam_req | output | 1 | Forced-collision request to the receive path |
| pause_send | output | 1 | One-cycle request to transmit a pause frame |
| pause_quanta | output | QUANTA_W | Pause time for the requested frame |
| tx_inhibit | output | 1 | Hold off starting new transmit frames |

## Verification
The bench builds the block with QUANTUM_SHIFT set to 2, so one quantum lasts four byte strobes. With that setting, counting the full inhibit window and the reload of a running timer takes tens of cycles, not thousands. XOFF_QUANTA is set to 0x00FF so the bench can tell a high-mark pause apart from the external pause values. The length register stays at its 6-bit width, which lets the bench run the default length, the zero-length case, a short length and a long length that is cut off by leaving half duplex.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic {
        FC_SEL_ENABLE = 1'b0,
        FC_SEL_BPLEN  = 1'b1
    } fc_sel_e;

    localparam int unsigned FC_EN_RXFD = 0;
    localparam int unsigned FC_EN_TXFD = 1;
    localparam int unsigned FC_EN_HD   = 2;
    localparam int unsigned FC_EN_W    = 3;
    localparam logic [FC_EN_W-1:0] FC_EN_RESET = 3'b111;
    localparam int unsigned FC_REG_W = 32;
endpackage

// File: rtl/fc_regs.sv
module fc_regs
    import fc_pkg::*;
#(
    parameter int unsigned BPL_W   = 6,
    parameter int unsigned BPL_RST = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 sel,
    input  logic [FC_REG_W-1:0]  wdata,
    output logic [FC_REG_W-1:0]  rdata,
    output logic [FC_EN_W-1:0]   en_bits,
    output logic [BPL_W-1:0]     bp_len
);
    typedef struct packed {
        logic [FC_EN_W-1:0] en;
        logic [BPL_W-1:0]   len;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (sel == FC_SEL_ENABLE) s_d.en  = wdata[FC_EN_W-1:0];
            else                      s_d.len = wdata[BPL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.en  <= FC_EN_RESET;
            s_q.len <= BPL_W'(BPL_RST);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel == FC_SEL_ENABLE) rdata[FC_EN_W-1:0] = s_q.en;
        else                      rdata[BPL_W-1:0]   = s_q.len;
    end

    assign en_bits = s_q.en;
    assign bp_len  = s_q.len;
endmodule

// File: rtl/fc_backpressure.sv
module fc_backpressure #(
    parameter int unsigned BPL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_tick,
    input  logic             enable,
    input  logic             half_duplex,
    input  logic             wm_high,
    input  logic             rx_carrier,
    input  logic [BPL_W-1:0] bp_len,
    output logic             jam
);
    typedef struct packed {
        logic             active;
        logic             armed;
        logic [BPL_W-1:0] cnt;
    } bp_t;

    bp_t s_d, s_q;
    logic             run;
    logic [BPL_W-1:0] len_eff;
    logic [BPL_W-1:0] cnt_nx;

    always_comb begin
        run     = enable && half_duplex;
        len_eff = (bp_len == '0) ? BPL_W'(1) : bp_len;
        cnt_nx  = (byte_tick && s_q.cnt != '0) ? s_q.cnt - 1'b1 : s_q.cnt;
        s_d     = s_q;
        if (!wm_high) s_d.armed = 1'b1;
        if (s_q.active) begin
            if (!run) begin
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = cnt_nx;
                if (cnt_nx == '0 && !rx_carrier) s_d.active = 1'b0;
            end
        end else if (run && wm_high && s_q.armed) begin
            s_d.active = 1'b1;
            s_d.cnt    = len_eff;
            s_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.active <= 1'b0;
            s_q.armed  <= 1'b1;
            s_q.cnt    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign jam = s_q.active;
endmodule

// File: rtl/fc_pause_gen.sv
module fc_pause_gen #(
    parameter int unsigned      QW          = 16,
    parameter logic [QW-1:0]    XOFF_QUANTA = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          half_duplex,
    input  logic          wm_high,
    input  logic          wm_low,
    input  logic          ext_req,
    input  logic [QW-1:0] ext_quanta,
    output logic          send,
    output logic [QW-1:0] quanta
);
    typedef struct packed {
        logic          send;
        logic [QW-1:0] quanta;
        logic          paused;
        logic          ext_pend;
        logic          ext_prev;
    } pg_t;

    pg_t  s_d, s_q;
    logic active;
    logic pend_now;

    always_comb begin
        active     = enable && !half_duplex;
        pend_now   = s_q.ext_pend || (ext_req && !s_q.ext_prev);
        s_d          = s_q;
        s_d.send     = 1'b0;
        s_d.ext_prev = ext_req;
        s_d.ext_pend = pend_now;
        if (!active) begin
            s_d.ext_pend = 1'b0;
            s_d.paused   = 1'b0;
        end else if (wm_high && !s_q.paused) begin
            s_d.send   = 1'b1;
            s_d.quanta = XOFF_QUANTA;
            s_d.paused = 1'b1;
        end else if (s_q.paused && wm_low) begin
            s_d.send   = 1'b1;
            s_d.quanta = '0;
            s_d.paused = 1'b0;
        end else if (pend_now) begin
            s_d.send     = 1'b1;
            s_d.quanta   = ext_quanta;
            s_d.ext_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign send   = s_q.send;
    assign quanta = s_q.quanta;
endmodule

// File: rtl/fc_pause_obey.sv
module fc_pause_obey #(
    parameter int unsigned QW            = 16,
    parameter int unsigned QUANTUM_SHIFT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_tick,
    input  logic          enable,
    input  logic          rx_valid,
    input  logic [QW-1:0] rx_time,
    input  logic          frame_active,
    output logic          inhibit
);
    localparam int unsigned CNT_W = QW + QUANTUM_SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             inh;
    } po_t;

    po_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!enable) begin
            s_d.cnt = '0;
        end else if (rx_valid) begin
            s_d.cnt = CNT_W'(rx_time) << QUANTUM_SHIFT;
        end else if (byte_tick && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        s_d.inh = (s_d.cnt != '0) && (s_q.inh || !frame_active);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign inhibit = s_q.inh;
endmodule

// File: rtl/eth_fc_ctrl.sv
module eth_fc_ctrl
    import fc_pkg::*;
#(
    parameter int unsigned           QUANTA_W      = 16,
    parameter int unsigned           QUANTUM_SHIFT = 6,
    parameter int unsigned           BPL_W         = 6,
    parameter int unsigned           BPL_RST       = 12,
    parameter logic [QUANTA_W-1:0]   XOFF_QUANTA   = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_tick,
    input  logic                half_duplex,
    input  logic                wm_high,
    input  logic                wm_low,
    input  logic                rx_carrier,
    input  logic                tx_frame_active,
    input  logic                tx_pause_req,
    input  logic [QUANTA_W-1:0] tx_pause_quanta,
    input  logic                rx_pause_valid,
    input  logic [QUANTA_W-1:0] rx_pause_time,
    input  logic                reg_wr_en,
    input  logic                reg_sel,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                jam_req,
    output logic                pause_send,
    output logic [QUANTA_W-1:0] pause_quanta,
    output logic                tx_inhibit
);
    logic [FC_EN_W-1:0] en_bits;
    logic [BPL_W-1:0]   bp_len;

    fc_regs #(.BPL_W(BPL_W), .BPL_RST(BPL_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
        .wdata(reg_wdata), .rdata(reg_rdata), .en_bits(en_bits), .bp_len(bp_len)
    );

    fc_backpressure #(.BPL_W(BPL_W)) u_bp (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick),
        .enable(en_bits[FC_EN_HD]), .half_duplex(half_duplex),
        .wm_high(wm_high), .rx_carrier(rx_carrier), .bp_len(bp_len), .jam(jam_req)
    );

    fc_pause_gen #(.QW(QUANTA_W), .XOFF_QUANTA(XOFF_QUANTA)) u_gen (
        .clk(clk), .rst_n(rst_n), .enable(en_bits[FC_EN_TXFD]),
        .half_duplex(half_duplex), .wm_high(wm_high), .wm_low(wm_low),
        .ext_req(tx_pause_req), .ext_quanta(tx_pause_quanta),
        .send(pause_send), .quanta(pause_quanta)
    );

    fc_pause_obey #(.QW(QUANTA_W), .QUANTUM_SHIFT(QUANTUM_SHIFT)) u_obey (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick),
        .enable(en_bits[FC_EN_RXFD]), .rx_valid(rx_pause_valid),
        .rx_time(rx_pause_time), .frame_active(tx_frame_active), .inhibit(tx_inhibit)
    );
endmodule

// File: rtl/fc_ctrl_checker.sv
module fc_ctrl_checker #(
    parameter int unsigned QW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          half_duplex,
    input logic          wm_high,
    input logic          rx_carrier,
    input logic          jam_req,
    input logic [2:0]    en_bits,
    input logic          pause_send,
    input logic          tx_inhibit,
    input logic          tx_frame_active,
    input logic          rx_pause_valid,
    input logic [QW-1:0] rx_pause_time
);
    a_r3_jam_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> ($past(wm_high) && $past(half_duplex) && $past(en_bits[2])));

    a_r5_jam_held_by_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (jam_req && rx_carrier && half_duplex && en_bits[2]) |=> jam_req);

    a_r6_jam_needs_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duplex |=> !jam_req);

    a_r10_no_pause_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_bits[1] |=> !pause_send);

    a_r10_no_pause_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        half_duplex |=> !pause_send);

    a_r12_zero_time_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_valid && rx_pause_time == '0) |=> !tx_inhibit);

    a_r12_rx_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_bits[0] |=> !tx_inhibit);

    a_r13_frame_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> !$past(tx_frame_active));
endmodule

bind eth_fc_ctrl fc_ctrl_checker #(.QW(QUANTA_W)) u_fc_chk (
    .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .wm_high(wm_high),
    .rx_carrier(rx_carrier), .jam_req(jam_req), .en_bits(en_bits),
    .pause_send(pause_send), .tx_inhibit(tx_inhibit),
    .tx_frame_active(tx_frame_active), .rx_pause_valid(rx_pause_valid),
    .rx_pause_time(rx_pause_time)
);

// File: tb/eth_fc_ctrl_test.sv
`timescale 1ns/1ps
module eth_fc_ctrl_test;
    localparam int unsigned QW = 16;
    localparam logic [QW-1:0] XOFF = 16'h00FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_tick = 1'b1;
    logic half_duplex = 1'b0, wm_high = 1'b0, wm_low = 1'b0;
    logic rx_carrier = 1'b0, tx_frame_active = 1'b0;
    logic tx_pause_req = 1'b0;
    logic [QW-1:0] tx_pause_quanta = '0;
    logic rx_pause_valid = 1'b0;
    logic [QW-1:0] rx_pause_time = '0;
    logic reg_wr_en = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic jam_req, pause_send, tx_inhibit;
    logic [QW-1:0] pause_quanta;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    q;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    eth_fc_ctrl #(.QUANTA_W(QW), .QUANTUM_SHIFT(2), .XOFF_QUANTA(XOFF)) uut (
        .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .half_duplex(half_duplex),
        .wm_high(wm_high), .wm_low(wm_low), .rx_carrier(rx_carrier),
        .tx_frame_active(tx_frame_active), .tx_pause_req(tx_pause_req),
        .tx_pause_quanta(tx_pause_quanta), .rx_pause_valid(rx_pause_valid),
        .rx_pause_time(rx_pause_time), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .jam_req(jam_req),
        .pause_send(pause_send), .pause_quanta(pause_quanta), .tx_inhibit(tx_inhibit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, input int exp, input string tag);
        reg_sel = sel;
        #0.5;
        chk(reg_rdata == 32'(exp), tag, int'(reg_rdata), exp);
    endtask

    function automatic void expect_pause(input int q, input string tag);
        exp_t e;
        e.q = q; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    // monitor: compares every pause request against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && pause_send) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected pause_send", int'(pause_quanta), -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(int'(pause_quanta) == e.q, e.tag, int'(pause_quanta), e.q);
            end
        end
    end

    // raise wm_high, check start, measure jam length, check no restart
    task automatic jam_measure(input int exp_len, input string tag);
        int n;
        wm_high = 1'b1;
        tick();
        chk(jam_req == 1'b1, "R3 jam starts after high mark", int'(jam_req), 1);
        n = 0;
        while (jam_req && n < 200) begin
            tick();
            n++;
        end
        chk(n == exp_len, tag, n, exp_len);
        tick(4);
        chk(jam_req == 1'b0, "R6 no restart while wm_high held", int'(jam_req), 0);
        wm_high = 1'b0;
        tick();
    endtask

    task automatic rx_pause(input int t);
        rx_pause_valid = 1'b1; rx_pause_time = QW'(t);
        tick();
        rx_pause_valid = 1'b0;
    endtask

    task automatic inhibit_count(input int exp, input string tag);
        int n;
        n = 0;
        while (tx_inhibit && n < 500) begin
            tick();
            n++;
        end
        chk(n == exp, tag, n, exp);
    endtask

    initial begin
        tick(3);
        chk(jam_req == 0 && pause_send == 0 && tx_inhibit == 0, "R1 outputs low in reset",
            int'({jam_req, pause_send, tx_inhibit}), 0);
        rst_n = 1'b1;
        tick();
        rd(1'b0, 7, "R1 enable reset value");
        rd(1'b1, 12, "R1 length reset value");

        // R2: reserved bits ignored
        wr(1'b0, 32'hFFFF_FFF8);
        rd(1'b0, 0, "R2 enable keeps bits 2:0 only");
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, 7, "R2 enable all ones");
        wr(1'b1, 32'hFFFF_FFC5);
        rd(1'b1, 5, "R2 length keeps bits 5:0 only");

        // back-pressure in half duplex
        half_duplex = 1'b1;
        wr(1'b1, 32'd12);
        jam_measure(12, "R4 jam length default 12");
        wr(1'b1, 32'd0);
        jam_measure(1, "R4 zero length counts as 1");
        wr(1'b1, 32'd3);
        jam_measure(3, "R4 jam length 3");

        // R5 carrier extends jam
        wr(1'b1, 32'd2);
        rx_carrier = 1'b1;
        wm_high = 1'b1;
        tick();
        tick(8);
        chk(jam_req == 1'b1, "R5 jam held while carrier", int'(jam_req), 1);
        rx_carrier = 1'b0;
        tick();
        chk(jam_req == 1'b0, "R5 jam drops after carrier ends", int'(jam_req), 0);
        wm_high = 1'b0;
        tick();

        // R6 leaving half duplex aborts jam
        wr(1'b1, 32'd40);
        wm_high = 1'b1;
        tick(4);
        chk(jam_req == 1'b1, "R6 long jam running", int'(jam_req), 1);
        half_duplex = 1'b0; wm_high = 1'b0;
        tick();
        chk(jam_req == 1'b0, "R6 jam drops leaving half duplex", int'(jam_req), 0);

        // R6 enable bit 2 clear: no jam
        half_duplex = 1'b1;
        wr(1'b0, 32'h3);
        wm_high = 1'b1;
        tick(5);
        chk(jam_req == 1'b0, "R6 no jam with bit 2 clear", int'(jam_req), 0);
        wm_high = 1'b0;
        half_duplex = 1'b0;
        wr(1'b0, 32'h7);
        tick(2);

        // pause generation, full duplex
        expect_pause(int'(XOFF), "R7 high-mark pause quanta");
        wm_high = 1'b1;
        tick(6);
        expect_pause(0, "R8 release pause quanta");
        wm_high = 1'b0; wm_low = 1'b1;
        tick(3);
        wm_low = 1'b0;

        expect_pause(16'h0123, "R9 external pause quanta");
        tx_pause_quanta = 16'h0123; tx_pause_req = 1'b1;
        tick(4);
        tx_pause_req = 1'b0;
        tick(2);

        expect_pause(int'(XOFF), "R9 watermark first on collision");
        expect_pause(16'h0055, "R9 external held one cycle");
        tx_pause_quanta = 16'h0055; tx_pause_req = 1'b1; wm_high = 1'b1;
        tick(4);
        tx_pause_req = 1'b0;
        expect_pause(0, "R8 release after collision case");
        wm_high = 1'b0; wm_low = 1'b1;
        tick(3);
        wm_low = 1'b0;
        tick(2);
        chk(exp_q.size() == 0, "R7 R8 R9 all expected pauses seen", exp_q.size(), 0);

        // R10 disabled: monitor flags any pause_send
        wr(1'b0, 32'h5);
        wm_high = 1'b1; tx_pause_req = 1'b1;
        tick(4);
        wm_high = 1'b0; wm_low = 1'b1; tx_pause_req = 1'b0;
        tick(3);
        wm_low = 1'b0;
        wr(1'b0, 32'h7);
        tick(3);
        chk(exp_q.size() == 0, "R10 nothing sent while disabled", exp_q.size(), 0);

        // R11 inhibit duration: N * 4 strobes
        rx_pause(3);
        chk(tx_inhibit == 1'b1, "R11 inhibit asserted", int'(tx_inhibit), 1);
        inhibit_count(12, "R11 inhibit lasts 3 quanta");
        rx_pause(5);
        tick(4);
        rx_pause(2);
        chk(tx_inhibit == 1'b1, "R11 inhibit still on at reload", int'(tx_inhibit), 1);
        inhibit_count(8, "R11 reload restarts timer");

        // R12 zero time and disabled
        rx_pause(10);
        tick(3);
        rx_pause(0);
        chk(tx_inhibit == 1'b0, "R12 zero time clears inhibit", int'(tx_inhibit), 0);
        wr(1'b0, 32'h6);
        rx_pause(4);
        tick(3);
        chk(tx_inhibit == 1'b0, "R12 ignored with bit 0 clear", int'(tx_inhibit), 0);
        wr(1'b0, 32'h7);

        // R13 frame boundary
        tx_frame_active = 1'b1;
        rx_pause(2);
        tick(3);
        chk(tx_inhibit == 1'b0, "R13 no inhibit during frame", int'(tx_inhibit), 0);
        tx_frame_active = 1'b0;
        tick();
        chk(tx_inhibit == 1'b1, "R13 inhibit after frame ends", int'(tx_inhibit), 1);
        inhibit_count(4, "R11 remaining time after frame");

        tick(3);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule